// File: doc/BRIEF.md
# Falling-Edge GPIO Interrupt Cause Collector

This block watches a bank of general-purpose input pins and turns high-to-low transitions on them into latched interrupt causes. Each pin passes through a two-stage synchronizer. A per-pin falling-edge enable decides whether a transition on that pin may latch its cause bit. A separate per-pin event enable decides whether a latched cause takes part in the interrupt. Software reads the raw causes and also the enabled causes, which are the raw causes masked by the event enable. This lets a handler on a shared interrupt line tell whether a particular pin (pin 12 by default) raised the request.

A cause bit stays set until software writes a one to that pin's bit in the clear-cause register. Until then the pin raises no further interrupt. Two sticky summary flags collect the enabled causes of two configurable pin groups and drive the shared line. Any clear-cause write that carries at least one set bit also drops both summary flags. The interrupt output is a registered OR of all enabled causes.

All control is through a simple 32-bit register bus. Writes take effect on the clock edge where the write strobe is high. Read data is a combinational decode of the address.

Top module: `gpio_fall_cause_unit`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every register reads zero, and irq_o, sum_a_o and sum_b_o are low.
- R2: Register map:
  - Cause bit n, readable at 0x80, corresponds to pin n.
  - A cause bit is set only by a high-to-low transition on a pin whose falling-edge enable bit (0x84, read/write) is one.
  - Rising edges, and falling edges on disabled pins, leave the cause unchanged.
- R3: A pin change made before clock edge E1 reaches the cause register at edge E3 (two synchronizer flops plus the cause flop), and not at E1 or E2.
- R4: The enabled-cause register at 0x8C reads the cause bits AND the event-enable register (0x88, read/write).
- R5: irq_o is high exactly one clock after some enabled cause is set, and is low one clock after none is.
- R6: Writing to the clear-cause register at 0x98:
  - A one in bit n clears cause n, and the cause stays clear until a new enabled falling edge.
  - Zero bits leave their causes unchanged.
- R7: When an enabled falling edge and a clear write for the same pin meet at one clock edge, the cause bit stays set.
- R8: Summary flags:
  - Summary flag A (0x90 bit 0, port sum_a_o) covers all pins. Summary flag B (0x90 bit 1, port sum_b_o) covers pin 12 only.
  - Each flag sets one clock after an enabled cause in its group is set, and holds (sticky).
  - Each flag clears at the edge of any clear-cause write with a nonzero data field.
- R9: Writes to the read-only addresses 0x80, 0x8C and 0x90 have no effect, and 0x98 always reads zero.
- R10: A cause latches even when its event-enable bit is zero. It is then visible at 0x80 but not at 0x8C, and does not drive irq_o until the event enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | NPINS | Asynchronous pin inputs |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Registered OR of enabled causes |
| sum_a_o | output | 1 | Summary flag for group A |
| sum_b_o | output | 1 | Summary flag for group B |

## Verification
On every cycle, the assertions check the following:
- no cause bit rises without an enabled edge in the prior cycle;
- a clear drops its causes unless an edge coincides;
- an edge wins over a coinciding clear;
- the summary flags are sticky and drop on a clear;
- irq_o tracks the enabled causes one cycle late.

Only the bench scenarios can show the rest:
- the exact three-edge synchronizer latency seen from the pins;
- the register decode, including ignored writes to read-only addresses;
- the group membership of the two summary flags;
- the masking of a latched but disabled cause.

// File: rtl/gfc_pkg.sv
// Shared constants for the falling-edge cause collector.
// Assumes a byte-addressed 32-bit register bus with 8-bit addresses.
package gfc_pkg;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned BUS_AW = 8;

    localparam logic [BUS_AW-1:0] A_CAUSE   = 8'h80;
    localparam logic [BUS_AW-1:0] A_FALLEN  = 8'h84;
    localparam logic [BUS_AW-1:0] A_EVTEN   = 8'h88;
    localparam logic [BUS_AW-1:0] A_ENCAUSE = 8'h8C;
    localparam logic [BUS_AW-1:0] A_SUMMARY = 8'h90;
    localparam logic [BUS_AW-1:0] A_CLEAR   = 8'h98;
endpackage

// File: rtl/gfc_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes each pin is independent; stages reset to zero.
module gfc_sync #(
    parameter int unsigned NPINS  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] async_i,
    output logic [NPINS-1:0] sync_o
);
    logic [NPINS-1:0] stage_q [STAGES];

    // first stage captures the raw pins
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // later stages shift the captured value along
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gfc_edge_detect.sv
// Per-pin high-to-low transition detector on synchronized inputs.
// Assumes input is already synchronous; output is a one-cycle pulse.
module gfc_edge_detect #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_i,
    output logic [NPINS-1:0] fall_o
);
    logic [NPINS-1:0] prev_q;

    // remember last synchronized value
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    assign fall_o = prev_q & ~sync_i;
endmodule

// File: rtl/gfc_cause_bank.sv
// Latched cause bits: set on enabled falling edges, cleared by write-one.
// Assumes a set and a clear on the same pin in one cycle resolve to set.
module gfc_cause_bank #(
    parameter int unsigned NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] fall_i,
    input  logic [NPINS-1:0] fall_en_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] cause_o
);
    logic [NPINS-1:0] cause_q;
    logic [NPINS-1:0] set_vec;

    assign set_vec = fall_i & fall_en_i;

    // clear first, then let new edges win
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr_i) | set_vec;
    end

    assign cause_o = cause_q;

    // R2: a cause bit never rises without an enabled edge
    p_set_needs_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec == '0) |=> ((cause_q & ~$past(cause_q)) == '0));

    // R6: cleared bits drop when no edge coincides
    p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i != '0) && ((set_vec & clr_i) == '0)) |=> ((cause_q & $past(clr_i)) == '0));

    // R7: an edge meeting a clear keeps the bit set
    p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec & clr_i) != '0) |=> ((cause_q & $past(set_vec & clr_i)) == $past(set_vec & clr_i)));
endmodule

// File: rtl/gfc_summary.sv
// Registered interrupt output and sticky grouped summary flags.
// Assumes MASKS holds NSUM pin masks of NPINS bits, group g at [g*NPINS +: NPINS].
module gfc_summary #(
    parameter int unsigned          NPINS = 16,
    parameter int unsigned          NSUM  = 2,
    parameter logic [NSUM*NPINS-1:0] MASKS = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] en_cause_i,
    input  logic             clr_any_i,
    output logic             irq_o,
    output logic [NSUM-1:0]  sum_o
);
    logic [NSUM-1:0] sum_q;

    // interrupt follows any enabled cause one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |en_cause_i;
    end

    for (genvar g = 0; g < NSUM; g++) begin : g_sum
        logic pending;
        assign pending = |(en_cause_i & MASKS[g*NPINS +: NPINS]);

        // sticky flag, dropped by any clear write
        always_ff @(posedge clk) begin
            if (!rst_n)         sum_q[g] <= 1'b0;
            else if (clr_any_i) sum_q[g] <= 1'b0;
            else if (pending)   sum_q[g] <= 1'b1;
        end

        // R8: a clear write always drops the flag
        p_sum_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            clr_any_i |=> !sum_q[g]);

        // R8: the flag holds until a clear
        p_sum_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (sum_q[g] && !clr_any_i) |=> sum_q[g]);
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/gfc_regfile.sv
// Register decode: enable registers, clear strobe and read multiplexer.
// Assumes single-cycle writes and combinational reads; NPINS <= 32.
module gfc_regfile
    import gfc_pkg::*;
#(
    parameter int unsigned NPINS = 16,
    parameter int unsigned NSUM  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BUS_AW-1:0] addr_i,
    input  logic [BUS_DW-1:0] wdata_i,
    output logic [BUS_DW-1:0] rdata_o,
    input  logic [NPINS-1:0]  cause_i,
    input  logic [NSUM-1:0]   sum_i,
    output logic [NPINS-1:0]  fall_en_o,
    output logic [NPINS-1:0]  evt_en_o,
    output logic [NPINS-1:0]  en_cause_o,
    output logic [NPINS-1:0]  clr_o,
    output logic              clr_any_o
);
    logic [NPINS-1:0] fall_en_q;
    logic [NPINS-1:0] evt_en_q;
    logic [NPINS-1:0] wbits;

    assign wbits = wdata_i[NPINS-1:0];

    if (NPINS < BUS_DW) begin : g_pad
        logic wdata_unused;
        assign wdata_unused = ^wdata_i[BUS_DW-1:NPINS];
    end

    // falling-edge enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                          fall_en_q <= '0;
        else if (wr_i && addr_i == A_FALLEN) fall_en_q <= wbits;
    end

    // event enable register
    always_ff @(posedge clk) begin
        if (!rst_n)                         evt_en_q <= '0;
        else if (wr_i && addr_i == A_EVTEN) evt_en_q <= wbits;
    end

    // write-one-to-clear strobe
    always_comb begin
        clr_o = '0;
        if (wr_i && addr_i == A_CLEAR) clr_o = wbits;
    end

    assign clr_any_o  = |clr_o;
    assign en_cause_o = cause_i & evt_en_q;
    assign fall_en_o  = fall_en_q;
    assign evt_en_o   = evt_en_q;

    // read multiplexer
    always_comb begin
        unique case (addr_i)
            A_CAUSE:   rdata_o = BUS_DW'(cause_i);
            A_FALLEN:  rdata_o = BUS_DW'(fall_en_q);
            A_EVTEN:   rdata_o = BUS_DW'(evt_en_q);
            A_ENCAUSE: rdata_o = BUS_DW'(en_cause_o);
            A_SUMMARY: rdata_o = BUS_DW'(sum_i);
            default:   rdata_o = '0;
        endcase
    end

    // R9: read-only and clear addresses never move the enable registers
    p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != A_FALLEN && addr_i != A_EVTEN) |=> $stable(fall_en_q) && $stable(evt_en_q));
endmodule

// File: rtl/gpio_fall_cause_unit.sv
// Top: synchronizes pins, detects falling edges, latches causes, masks them
// and drives the interrupt and two grouped summary flags.
// Assumes pins idle high; synchronous active-low reset.
module gpio_fall_cause_unit
    import gfc_pkg::*;
#(
    parameter int unsigned     NPINS       = 16,
    parameter int unsigned     SYNC_STAGES = 2,
    parameter logic [NPINS-1:0] SUM_A_MASK = '1,
    parameter logic [NPINS-1:0] SUM_B_MASK = NPINS'(1) << 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pins_i,
    input  logic              bus_wr_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [BUS_DW-1:0] bus_wdata_i,
    output logic [BUS_DW-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              sum_a_o,
    output logic              sum_b_o
);
    localparam int unsigned NSUM = 2;
    localparam logic [NSUM*NPINS-1:0] MASKS = {SUM_B_MASK, SUM_A_MASK};

    logic [NPINS-1:0] sync_pins;
    logic [NPINS-1:0] fall;
    logic [NPINS-1:0] fall_en;
    logic [NPINS-1:0] evt_en;
    logic [NPINS-1:0] en_cause;
    logic [NPINS-1:0] clr;
    logic             clr_any;
    logic [NPINS-1:0] cause;
    logic [NSUM-1:0]  sums;

    gfc_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pins_i), .sync_o(sync_pins));

    gfc_edge_detect #(.NPINS(NPINS)) u_edge (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_pins), .fall_o(fall));

    gfc_cause_bank #(.NPINS(NPINS)) u_cause (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .fall_en_i(fall_en),
        .clr_i(clr), .cause_o(cause));

    gfc_regfile #(.NPINS(NPINS), .NSUM(NSUM)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .cause_i(cause),
        .sum_i(sums), .fall_en_o(fall_en), .evt_en_o(evt_en),
        .en_cause_o(en_cause), .clr_o(clr), .clr_any_o(clr_any));

    gfc_summary #(.NPINS(NPINS), .NSUM(NSUM), .MASKS(MASKS)) u_sum (
        .clk(clk), .rst_n(rst_n), .en_cause_i(en_cause), .clr_any_i(clr_any),
        .irq_o(irq_o), .sum_o(sums));

    assign sum_a_o = sums[0];
    assign sum_b_o = sums[1];

    // R5: interrupt output tracks the enabled causes one cycle late
    p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(en_cause != '0)));

    // R10: with every event enable clear, the interrupt stays low
    p_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_en == '0) |=> !irq_o);
endmodule

// File: tb/gpio_fall_cause_unit_test.sv
module gpio_fall_cause_unit_test;
    localparam int NP = 16;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2, OP_IDLE = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,   8'h80, 32'h0,        8'd1},  // R1 cause
        '{OP_RD,   8'h84, 32'h0,        8'd1},  // R1 fall enable
        '{OP_RD,   8'h88, 32'h0,        8'd1},  // R1 event enable
        '{OP_RD,   8'h90, 32'h0,        8'd1},  // R1 summary
        '{OP_WR,   8'h84, 32'h1000,     8'd2},
        '{OP_WR,   8'h88, 32'h1000,     8'd4},
        '{OP_RD,   8'h84, 32'h1000,     8'd2},  // R2 enable readback
        '{OP_PIN,  8'h00, 32'hEFFF,     8'd2},  // pin 12 falls
        '{OP_RD,   8'h80, 32'h1000,     8'd2},  // R2 cause set
        '{OP_RD,   8'h8C, 32'h1000,     8'd4},  // R4 enabled cause
        '{OP_RD,   8'h90, 32'h3,        8'd8},  // R8 both groups
        '{OP_WR,   8'h98, 32'h1000,     8'd6},
        '{OP_RD,   8'h80, 32'h0,        8'd6},  // R6 cleared
        '{OP_RD,   8'h90, 32'h0,        8'd8},  // R8 flags dropped
        '{OP_PIN,  8'h00, 32'hFFFF,     8'd2},  // rising edge
        '{OP_RD,   8'h80, 32'h0,        8'd2},  // R2 rise ignored
        '{OP_PIN,  8'h00, 32'hFFF7,     8'd2},  // pin 3 falls, disabled
        '{OP_RD,   8'h80, 32'h0,        8'd2},  // R2 disabled pin ignored
        '{OP_WR,   8'h84, 32'h1008,     8'd2},
        '{OP_PIN,  8'h00, 32'hFFFF,     8'd2},
        '{OP_PIN,  8'h00, 32'hFFF7,     8'd10}, // pin 3 falls, enabled
        '{OP_RD,   8'h80, 32'h8,        8'd10}, // R10 latched while masked
        '{OP_RD,   8'h8C, 32'h0,        8'd10}, // R10 not in enabled view
        '{OP_WR,   8'h88, 32'h1008,     8'd10},
        '{OP_IDLE, 8'h00, 32'd3,        8'd10},
        '{OP_RD,   8'h90, 32'h1,        8'd8},  // R8 group A only
        '{OP_WR,   8'h80, 32'hFFFFFFFF, 8'd9},
        '{OP_WR,   8'h98, 32'h0,        8'd6},
        '{OP_RD,   8'h80, 32'h8,        8'd9},  // R9 / R6 unchanged
        '{OP_RD,   8'h98, 32'h0,        8'd9},  // R9 clear reads zero
        '{OP_WR,   8'h98, 32'h8,        8'd6},
        '{OP_RD,   8'h80, 32'h0,        8'd6}   // R6 pin 3 cleared
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '1;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq, sum_a, sum_b;
    int            checks = 0;
    int            fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    gpio_fall_cause_unit uut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .sum_a_o(sum_a), .sum_b_o(sum_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", 32'(irq), 0);
        check("R1 summary ports", 32'({sum_b, sum_a}), 0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", VEC[i].req, i);
            case (VEC[i].op)
                OP_WR:  bus_write(VEC[i].addr, VEC[i].data);
                OP_RD:  bus_read(tag, VEC[i].addr, VEC[i].data);
                OP_PIN: begin pins = VEC[i].data[NP-1:0]; repeat (5) @(negedge clk); end
                default: repeat (VEC[i].data) @(negedge clk);
            endcase
        end

        // R3 / R5 / R8: exact latency from pin 12 falling
        bus_write(8'h88, 32'h1000);
        pins = '1; repeat (5) @(negedge clk);
        pins[12] = 1'b0;
        @(negedge clk); bus_read("R3 after E1", 8'h80, 0);
        @(negedge clk); bus_read("R3 after E2", 8'h80, 0);
        @(negedge clk); bus_read("R3 after E3", 8'h80, 32'h1000);
        check("R5 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R5 irq raised", 32'(irq), 1);
        check("R8 summary ports", 32'({sum_b, sum_a}), 32'h3);
        bus_write(8'h98, 32'h1000);
        @(negedge clk);
        check("R5 irq dropped", 32'(irq), 0);
        check("R6 no re-raise", 32'(irq), 0);

        // R10: masked cause does not drive irq
        bus_write(8'h88, 32'h0);
        pins = '1; repeat (5) @(negedge clk);
        pins[12] = 1'b0; repeat (5) @(negedge clk);
        bus_read("R10 raw cause", 8'h80, 32'h1000);
        check("R10 irq masked", 32'(irq), 0);
        bus_write(8'h88, 32'h1000);
        @(negedge clk);
        check("R10 irq after enable", 32'(irq), 1);
        bus_write(8'h98, 32'h1000);

        // R7: edge and clear meet at one edge
        pins = '1; repeat (5) @(negedge clk);
        bus_read("R7 precondition", 8'h80, 0);
        pins[12] = 1'b0;
        @(negedge clk); @(negedge clk);
        bus_write(8'h98, 32'h1000);
        bus_read("R7 edge wins", 8'h80, 32'h1000);

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read("R1 cause after reset", 8'h80, 0);
        bus_read("R1 enable after reset", 8'h84, 0);
        check("R1 irq after reset", 32'(irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule